// File: doc/BRIEF.md
# SDRAM Refresh Timer and Sequencer

This block keeps a synchronous DRAM's contents alive. A prescaler derives a count clock from the system clock, with the division set by a 3-bit select field. An up-counter advances on that clock and is compared with a programmed interval. When the counter equals the interval, the counter wraps to zero and keeps counting, a match flag is raised, and a refresh request is posted. Once the bus is granted, a small sequencer drives the SDRAM command lines. It issues a precharge of all banks, waits a programmable gap, issues the refresh command, and then holds off further commands for a lockout period. The lockout length is the sum of two programmable delays.

A mode bit selects a different use of the same sequencer. Instead of periodic refresh, it places the SDRAM in low-power self-refresh. The sequencer precharges all banks, issues the self-refresh command with clock-enable driven low, and stays there. When the mode bit is cleared, clock-enable returns high and the sequencer waits out the lockout before it goes idle. Software writes four registers through a simple write port:

| Address | Register | Contents |
|---|---|---|
| 0 | Control | bit 0 refresh enable, bit 1 self-refresh mode, bits 4:2 gap code, bits 7:5 hold code |
| 1 | Clock select | bits 2:0 |
| 2 | Counter | counter value |
| 3 | Interval | interval value |

Top module: `sdram_refresh_ctrl`

## Requirements
- R1: While `rst` is high, after a clock edge, `sd_cmd` is NOP (0), `sd_cke` is 1, `cmp_flag` is 0 and `bus_req` is 0.
- R2: A clock-select value of 0 stops the counter. A nonzero value k makes the counter advance once every 2^(k-1) system clocks. With select 3 and interval 1, refreshes start exactly 8 cycles apart.
- R3: Writing a nonzero clock-select value does not change the counter. Counting resumes from the value the counter holds, whether that value was written or left over from an earlier run.
- R4: On a count where the counter equals the interval, the counter goes to 0, `cmp_flag` goes to 1 and a refresh request is posted. One match occurs every interval+1 counts.
- R5: `cmp_flag` is cleared on the clock edge at which the refresh cycle starts, that is, when the precharge-all command appears.
- R6: With refresh enable 1 and mode 0, a refresh cycle drives precharge-all (1) for one cycle, then NOP for gap+1 cycles, then refresh (2) for one cycle. Here gap is the 3-bit gap code.
- R7: After a refresh command, at least (hold+1)+(gap+1) NOP cycles pass before any further command. A refresh that is already pending starts right after that lockout.
- R8: A posted request waits until `bus_gnt` is 1. `bus_req` is 1 while a request is pending or a sequence is active. Several matches while a request waits produce a single refresh.
- R9: With refresh enable 1 and mode 1, the block issues precharge-all, waits gap+1 NOP cycles, and then issues self-refresh (3) with `sd_cke` low. `sd_cke` stays low with NOP while the mode bit stays 1.
- R10: Clearing the mode bit during self-refresh raises `sd_cke` on the next edge. The block then holds NOP for (hold+1)+(gap+1) cycles with `bus_req` still 1, and then goes idle with `bus_req` 0.
- R11: `sd_cmd` is NOP (0) whenever the sequencer is idle or inside a wait period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 clock select, 2 counter, 3 interval |
| wr_data | input | CNT_W | Write data |
| bus_gnt | input | 1 | Bus granted to the refresh sequencer |
| bus_req | output | 1 | Refresh sequencer needs the bus |
| sd_cmd | output | 2 | SDRAM command: 0 NOP, 1 precharge-all, 2 refresh, 3 self-refresh |
| sd_cke | output | 1 | SDRAM clock enable |
| cmp_flag | output | 1 | Counter/interval match flag |

## Verification
The bench uses the default parameters: an 8-bit counter, a 3-bit clock select and a prescaler step of one doubling per select code. Select 1 therefore counts on every clock. This makes every command's cycle exactly predictable, for periodic refresh, for resuming from a held counter value, and for merged requests held back by a withheld grant. An interval of 0 keeps a request pending at all times, so back-to-back sequences separated only by the lockout come within reach. Select 3 shows the divide-by-four spacing as 8-cycle refresh periods.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_PALL = 2'd1,
    CMD_REF  = 2'd2,
    CMD_SELF = 2'd3
  } sdcmd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_GAP, S_REF, S_LOCK,
    S_SPRE, S_SGAP, S_SENT, S_SHOLD
  } seq_e;
endpackage

// File: rtl/ref_prescaler.sv
module ref_prescaler #(
  parameter int SEL_W    = 3,
  parameter int PS_SHIFT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int SPAN = PS_SHIFT * ((1 << SEL_W) - 2);
  localparam int PS_W = (SPAN > 0) ? SPAN : 1;

  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] mask;
  int              shamt;

  always_ff @(posedge clk) begin
    if (rst) ps_q <= '0;
    else     ps_q <= ps_q + 1'b1;
  end

  always_comb begin
    shamt = (sel == '0) ? 0 : PS_SHIFT * (int'(sel) - 1);
    mask  = ({{(PS_W-1){1'b0}}, 1'b1} << shamt) - 1'b1;
    tick  = (sel != '0) && ((ps_q & mask) == '0);
  end
endmodule

// File: rtl/ref_timer.sv
module ref_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] ivl,
  input  logic             clr_flag,
  output logic             hit,
  output logic             flag,
  output logic [CNT_W-1:0] cnt
);
  assign hit = tick && !load && (cnt == ivl);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (load)      cnt <= load_val;
      else if (hit)  cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;

      if (hit)           flag <= 1'b1;
      else if (clr_flag) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/ref_sequencer.sv
module ref_sequencer
  import sdram_ref_pkg::*;
#(
  parameter int F_W = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hit,
  input  logic           auto_en,
  input  logic           self_en,
  input  logic [F_W-1:0] tpc,
  input  logic [F_W-1:0] tras,
  input  logic           bus_gnt,
  output logic           start,
  output logic [1:0]     cmd_o,
  output logic           cke_o,
  output logic           bus_req_o
);
  localparam int W_W = F_W + 1;

  seq_e           state_q, state_n;
  logic [W_W-1:0] wcnt_q, wcnt_n, lock_len;
  logic           pend_q, pend_n;

  assign lock_len = W_W'(tras) + W_W'(tpc) + W_W'(1);

  always_comb begin
    state_n = state_q;
    wcnt_n  = wcnt_q;
    case (state_q)
      S_IDLE: begin
        if (self_en && bus_gnt)     state_n = S_SPRE;
        else if (pend_q && bus_gnt) state_n = S_PRE;
      end
      S_PRE:  begin state_n = S_GAP; wcnt_n = W_W'(tpc); end
      S_GAP:  begin
        if (wcnt_q == '0) state_n = S_REF;
        else              wcnt_n  = wcnt_q - 1'b1;
      end
      S_REF:  begin state_n = S_LOCK; wcnt_n = lock_len; end
      S_LOCK: begin
        if (wcnt_q == '0) state_n = S_IDLE;
        else              wcnt_n  = wcnt_q - 1'b1;
      end
      S_SPRE: begin state_n = S_SGAP; wcnt_n = W_W'(tpc); end
      S_SGAP: begin
        if (wcnt_q == '0) state_n = S_SENT;
        else              wcnt_n  = wcnt_q - 1'b1;
      end
      S_SENT:  state_n = S_SHOLD;
      S_SHOLD: begin
        if (!self_en) begin state_n = S_LOCK; wcnt_n = lock_len; end
      end
      default: state_n = S_IDLE;
    endcase

    start = (state_q == S_IDLE) && (state_n == S_PRE);

    if (hit && auto_en)      pend_n = 1'b1;
    else if (start || !auto_en) pend_n = 1'b0;
    else                     pend_n = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      wcnt_q    <= '0;
      pend_q    <= 1'b0;
      cmd_o     <= CMD_NOP;
      cke_o     <= 1'b1;
      bus_req_o <= 1'b0;
    end else begin
      state_q <= state_n;
      wcnt_q  <= wcnt_n;
      pend_q  <= pend_n;
      case (state_n)
        S_PRE, S_SPRE: cmd_o <= CMD_PALL;
        S_REF:         cmd_o <= CMD_REF;
        S_SENT:        cmd_o <= CMD_SELF;
        default:       cmd_o <= CMD_NOP;
      endcase
      cke_o     <= !((state_n == S_SENT) || (state_n == S_SHOLD));
      bus_req_o <= (state_n != S_IDLE) || pend_n || self_en;
    end
  end
endmodule

// File: rtl/sdram_refresh_ctrl.sv
module sdram_refresh_ctrl #(
  parameter int CNT_W    = 8,
  parameter int SEL_W    = 3,
  parameter int F_W      = 3,
  parameter int PS_SHIFT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             bus_gnt,
  output logic             bus_req,
  output logic [1:0]       sd_cmd,
  output logic             sd_cke,
  output logic             cmp_flag
);
  localparam int CTRL_W  = 2 + 2 * F_W;
  localparam int TPC_LO  = 2;
  localparam int TRAS_LO = 2 + F_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [SEL_W-1:0]  sel_q;
  logic [CNT_W-1:0]  ivl_q, cnt_v;
  logic [F_W-1:0]    tpc_f, tras_f;
  logic              tick, hit, start, cnt_load, auto_en, self_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      sel_q  <= '0;
      ivl_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0:    ctrl_q <= wr_data[CTRL_W-1:0];
        2'd1:    sel_q  <= wr_data[SEL_W-1:0];
        2'd3:    ivl_q  <= wr_data;
        default: ;
      endcase
    end
  end

  assign cnt_load = wr_en && (wr_addr == 2'd2);
  assign tpc_f    = ctrl_q[TPC_LO +: F_W];
  assign tras_f   = ctrl_q[TRAS_LO +: F_W];
  assign auto_en  = ctrl_q[0] && !ctrl_q[1];
  assign self_en  = ctrl_q[0] && ctrl_q[1];

  ref_prescaler #(.SEL_W(SEL_W), .PS_SHIFT(PS_SHIFT)) u_ps (
    .clk(clk), .rst(rst), .sel(sel_q), .tick(tick)
  );

  ref_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .tick(tick), .load(cnt_load), .load_val(wr_data),
    .ivl(ivl_q), .clr_flag(start), .hit(hit), .flag(cmp_flag), .cnt(cnt_v)
  );

  ref_sequencer #(.F_W(F_W)) u_seq (
    .clk(clk), .rst(rst), .hit(hit), .auto_en(auto_en), .self_en(self_en),
    .tpc(tpc_f), .tras(tras_f), .bus_gnt(bus_gnt), .start(start),
    .cmd_o(sd_cmd), .cke_o(sd_cke), .bus_req_o(bus_req)
  );
endmodule

// File: rtl/sdram_refresh_chk.sv
module sdram_refresh_chk #(
  parameter int CNT_W = 8,
  parameter int F_W   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       cmd,
  input logic             cke,
  input logic             flag,
  input logic             bus_req,
  input logic             bus_gnt,
  input logic [F_W-1:0]   tpc,
  input logic [F_W-1:0]   tras,
  input logic             tick,
  input logic             load,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] ivl
);
  localparam int SW = F_W + 3;
  localparam logic [SW-1:0] SAT = '1;

  logic [SW-1:0] since_pall, since_ref, lock_need;
  logic          seen_ref;

  assign lock_need = SW'(tras) + SW'(tpc) + SW'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      since_pall <= SAT;
      since_ref  <= SAT;
      seen_ref   <= 1'b0;
    end else begin
      since_pall <= (cmd == 2'd1) ? '0 : (since_pall == SAT ? SAT : since_pall + 1'b1);
      since_ref  <= (cmd == 2'd2) ? '0 : (since_ref == SAT ? SAT : since_ref + 1'b1);
      if (cmd == 2'd2) seen_ref <= 1'b1;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (cmd == 2'd0 && cke && !flag && !bus_req));

  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && cnt == ivl) |=> (cnt == '0 && flag));

  a_r6_gap: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'd2) |-> (since_pall == SW'(tpc) + SW'(1)));

  a_r7_lockout: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'd1 && seen_ref) |-> (since_ref >= lock_need));

  a_r8_granted: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'd1) |-> $past(bus_gnt));

  a_r9_self_cke: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'd3) |-> !cke);

  a_r9_cke_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(cke) |-> (cmd == 2'd3));
endmodule

bind sdram_refresh_ctrl sdram_refresh_chk #(.CNT_W(CNT_W), .F_W(F_W)) chk_i (
  .clk(clk), .rst(rst), .cmd(sd_cmd), .cke(sd_cke), .flag(cmp_flag),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .tpc(tpc_f), .tras(tras_f),
  .tick(tick), .load(cnt_load), .cnt(cnt_v), .ivl(ivl_q)
);

// File: tb/sdram_refresh_ctrl_tb_top.sv
module sdram_refresh_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             bus_gnt = 1'b0;
  logic             bus_req, sd_cke, cmp_flag;
  logic [1:0]       sd_cmd;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit free_mode = 1'b0;
  bit done = 1'b0;

  logic [1:0] exp_cmd[$];
  int         exp_cyc[$];
  int         pall_log[$];

  sdram_refresh_ctrl #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bus_gnt(bus_gnt), .bus_req(bus_req), .sd_cmd(sd_cmd), .sd_cke(sd_cke),
    .cmp_flag(cmp_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cyc %0d act=%0d exp=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic push_exp(input logic [1:0] c, input int at);
    exp_cmd.push_back(c);
    exp_cyc.push_back(at);
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Monitor: every non-NOP command is popped from the scoreboard and compared
  always @(negedge clk) begin
    if (!rst && sd_cmd != 2'd0) begin
      if (free_mode) begin
        if (sd_cmd == 2'd1) pall_log.push_back(cyc);
      end else if (exp_cmd.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected command at cyc %0d act=%0d exp=0", cyc, sd_cmd);
      end else begin
        logic [1:0] ec;
        int         et;
        ec = exp_cmd.pop_front();
        et = exp_cyc.pop_front();
        checks++;
        if (ec != sd_cmd || et != cyc) begin
          errors++;
          $display("FAIL R6 command act=%0d@%0d exp=%0d@%0d", sd_cmd, cyc, ec, et);
        end
      end
    end
  end

  initial begin
    int e0, e1, e2, e3, e4, e5;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 cmd", sd_cmd, 0);
    check("R1 cke", sd_cke, 1);
    check("R1 flag", cmp_flag, 0);
    check("R1 bus_req", bus_req, 0);
    rst = 1'b0;
    bus_gnt = 1'b1;

    // Periodic auto refresh: gap code 1, hold code 2, interval 10, start at 5
    wr(2'd0, 1 + (1 << 2) + (2 << 5));
    wr(2'd3, 10);
    wr(2'd2, 5);
    wr(2'd1, 1);
    e0 = cyc;
    push_exp(2'd1, e0 + 7);  push_exp(2'd2, e0 + 10);
    push_exp(2'd1, e0 + 18); push_exp(2'd2, e0 + 21);
    wait_until(e0 + 6);
    check("R4 flag on match", cmp_flag, 1);
    check("R8 bus_req pending", bus_req, 1);
    wait_until(e0 + 7);
    check("R5 flag cleared at start", cmp_flag, 0);
    wait_until(e0 + 8);
    check("R11 NOP in gap", sd_cmd, 0);
    wait_until(e0 + 22);
    wr(2'd1, 0);                       // counter stops holding 7
    wait_until(cyc + 30);
    check("R2 stopped: no refresh", exp_cmd.size(), 0);
    check("R2 stopped: flag low", cmp_flag, 0);

    // R3 resume from held value 7
    wr(2'd1, 1);
    e1 = cyc;
    push_exp(2'd1, e1 + 5); push_exp(2'd2, e1 + 8);
    wait_until(e1 + 4);
    check("R3 match after resume", cmp_flag, 1);
    wait_until(e1 + 7);
    wr(2'd1, 0);
    wait_until(e1 + 16);
    check("R3 queue drained", exp_cmd.size(), 0);

    // R8 merge with grant withheld; gap code 3, hold code 0
    bus_gnt = 1'b0;
    wr(2'd0, 1 + (3 << 2));
    wr(2'd3, 2);
    wr(2'd2, 0);
    wr(2'd1, 1);
    e2 = cyc;
    wait_until(e2 + 3);
    check("R8 bus_req", bus_req, 1);
    check("R4 flag", cmp_flag, 1);
    wait_until(e2 + 6);
    wr(2'd1, 0);
    check("R8 waiting no command", sd_cmd, 0);
    push_exp(2'd1, e2 + 9); push_exp(2'd2, e2 + 14);
    bus_gnt = 1'b1;
    wait_until(e2 + 9);
    check("R5 flag cleared", cmp_flag, 0);
    wait_until(e2 + 25);
    check("R8 single merged refresh", exp_cmd.size(), 0);
    check("R8 bus_req released", bus_req, 0);

    // R7 back-to-back sequences limited by lockout; codes 0/0, interval 0
    wr(2'd0, 1);
    wr(2'd3, 0);
    wr(2'd2, 0);
    wr(2'd1, 1);
    e3 = cyc;
    push_exp(2'd1, e3 + 2);  push_exp(2'd2, e3 + 4);
    push_exp(2'd1, e3 + 8);  push_exp(2'd2, e3 + 10);
    push_exp(2'd1, e3 + 14); push_exp(2'd2, e3 + 16);
    wait_until(e3 + 7);
    wr(2'd1, 0);
    wait_until(e3 + 25);
    check("R7 lockout spacing", exp_cmd.size(), 0);

    // R9 / R10 self-refresh; gap code 1, hold code 1
    wr(2'd0, 1 + 2 + (1 << 2) + (1 << 5));
    e4 = cyc;
    push_exp(2'd1, e4 + 1); push_exp(2'd3, e4 + 4);
    wait_until(e4 + 4);
    check("R9 cke low on entry", sd_cke, 0);
    wait_until(e4 + 10);
    check("R9 cke held low", sd_cke, 0);
    check("R9 NOP while held", sd_cmd, 0);
    wr(2'd0, 1 + (1 << 2) + (1 << 5));
    e5 = cyc;
    check("R10 cke still low", sd_cke, 0);
    wait_until(e5 + 1);
    check("R10 cke high", sd_cke, 1);
    wait_until(e5 + 4);
    check("R10 bus_req in lockout", bus_req, 1);
    wait_until(e5 + 5);
    check("R10 bus_req idle", bus_req, 0);
    check("R9 self sequence", exp_cmd.size(), 0);

    // R2 divided count clock: select 3, interval 1 -> 8-cycle period
    wr(2'd0, 1);
    wr(2'd3, 1);
    wr(2'd2, 0);
    free_mode = 1'b1;
    wr(2'd1, 3);
    wait_until(cyc + 40);
    wr(2'd1, 0);
    wait_until(cyc + 20);
    free_mode = 1'b0;
    check("R2 refresh count", (pall_log.size() >= 3) ? 1 : 0, 1);
    for (int i = 1; i < pall_log.size(); i++)
      check("R2 period", pall_log[i] - pall_log[i-1], 8);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule